// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block turns one fetched instruction word of a small 16-bit RISC core into the fields and control strobes that the later pipeline stages need. The core mixes a 16-bit short format and a 32-bit long format. The fetch logic always presents a 32-bit window, with the instruction's first half-word in bits 15:0. The decoder works out the length from the opcode value alone, so the fetch stage learns how far to advance. It splits out the register, port and immediate fields. It raises one-hot selects for the ALU function and the jump kind, together with write-back, memory and port strobes. Opcodes with no meaning are flagged as illegal and are decoded as a no-operation.

The decode itself is pure logic. A parameter `REG_OUT` chooses between a pipeline register on every output (default, one cycle of latency, cleared by reset) and a plain combinational path.

Top module: `vl_insn_decoder`

## Requirements
- R1: `opcode_o` equals instruction bits 7:0. `long_o` is 1 exactly when that opcode is 0x20 or above; otherwise it is 0, which marks the 16-bit format.
- R2: `ra_o` equals instruction bits 11:8 in both formats.
- R3: In the short format, `rb_o` equals bits 15:12, which carry either the second register or a port number. `imm_o` is zero, and bits 31:16 have no effect on any output.
- R4: In the long format, `imm_o` equals bits 31:16. `rb_o` is zero, and the reserved bits 15:12 reach no output.
- R5: `alu_sel_o` sets one bit per ALU opcode and is zero for every other opcode. The mapping (bit:opcode) is 0:MOV 0x01, 1:AND 0x02, 2:OR 0x03, 3:NOT 0x04, 4:XOR 0x05, 5:ADD 0x06, 6:SUB 0x07, 7:INC 0x08, 8:DEC 0x09, 9:SHL 0x0A, 10:SHR 0x0B, 11:ROL 0x0C, 12:ROR 0x0D, 13:CMP 0x0E, 14:ADC 0x13, 15:SBB 0x14, 16:NEG 0x15, 17:ASL 0x16, 18:ASR 0x17, 19:load-constant 0x20, 20:load-next-address 0x19.
- R6: `reg_we_o` is 1 for every opcode that sets an `alu_sel_o` bit except CMP (0x0E). It is also 1 for memory load 0x0F and port read 0x11. It is 0 for all other opcodes.
- R7: `mem_rd_o` is 1 only for 0x0F, `mem_wr_o` only for 0x10, `port_rd_o` only for 0x11 and `port_wr_o` only for 0x12.
- R8: `jmp_sel_o` sets one bit per jump and is zero otherwise. The mapping is bit 0 for the register-indirect jump 0x18, and bit k (1..7) for opcode 0x20+k (unconditional, zero, not-zero, less, not-less, greater, not-greater).
- R9: Opcodes 0x1A–0x1F and 0x28–0xFF raise `illegal_o` and assert no control output (`alu_sel_o`, `jmp_sel_o`, `reg_we_o` and the four transfer strobes are all 0). Their field outputs still follow R1–R4.
- R10: Opcode 0x00 asserts no control output and does not raise `illegal_o`.
- R11: With `REG_OUT`=1, every output shows the decode of the word applied before the previous rising clock edge. An active-low reset `rst_ni` clears all outputs to zero at once.
- R12: At most one bit of `alu_sel_o` and at most one bit of `jmp_sel_o` is set, and at most one of the four transfer strobes is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Fetched instruction window, first half-word in bits 15:0 |
| opcode_o | output | 8 | Opcode field |
| long_o | output | 1 | 1 for the 32-bit format |
| ra_o | output | 4 | First register index |
| rb_o | output | 4 | Second register or port number (short format only) |
| imm_o | output | 16 | Immediate or jump address (long format only) |
| alu_sel_o | output | 21 | One-hot ALU function select |
| jmp_sel_o | output | 8 | One-hot jump kind |
| reg_we_o | output | 1 | Register write-back enable |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| port_rd_o | output | 1 | Port read |
| port_wr_o | output | 1 | Port write |
| illegal_o | output | 1 | Undefined opcode |

## Verification
The assertions check structural rules on every cycle. These cover the one-hot and exclusive strobes, a zero immediate in the short format, a zero second-register field in the long format, CMP never writing back, illegal opcodes staying silent, and illegal short opcodes lying in the gap above 0x19. Only the scenarios can show that each of the 256 opcodes maps to the right select bit and strobe set, and that upper or reserved bits truly have no effect on the outputs. The scenarios also show that results appear one edge after the word is applied and that reset clears outputs mid-stream.

// File: rtl/vl_dec_pkg.sv
package vl_dec_pkg;
  localparam int INSN_W = 32;
  localparam int OPC_W  = 8;
  localparam int REG_W  = 4;
  localparam int IMM_W  = 16;
  localparam int ALU_N  = 21;
  localparam int JMP_N  = 8;

  localparam int RA_LSB  = OPC_W;
  localparam int RB_LSB  = OPC_W + REG_W;
  localparam int IMM_LSB = INSN_W - IMM_W;

  localparam logic [OPC_W-1:0] LONG_BASE = 8'h20;

  // opcodes
  localparam logic [OPC_W-1:0] OP_NOP  = 8'h00;
  localparam logic [OPC_W-1:0] OP_MOV  = 8'h01;
  localparam logic [OPC_W-1:0] OP_AND  = 8'h02;
  localparam logic [OPC_W-1:0] OP_OR   = 8'h03;
  localparam logic [OPC_W-1:0] OP_NOT  = 8'h04;
  localparam logic [OPC_W-1:0] OP_XOR  = 8'h05;
  localparam logic [OPC_W-1:0] OP_ADD  = 8'h06;
  localparam logic [OPC_W-1:0] OP_SUB  = 8'h07;
  localparam logic [OPC_W-1:0] OP_INC  = 8'h08;
  localparam logic [OPC_W-1:0] OP_DEC  = 8'h09;
  localparam logic [OPC_W-1:0] OP_SHL  = 8'h0A;
  localparam logic [OPC_W-1:0] OP_SHR  = 8'h0B;
  localparam logic [OPC_W-1:0] OP_ROL  = 8'h0C;
  localparam logic [OPC_W-1:0] OP_ROR  = 8'h0D;
  localparam logic [OPC_W-1:0] OP_CMP  = 8'h0E;
  localparam logic [OPC_W-1:0] OP_LD   = 8'h0F;
  localparam logic [OPC_W-1:0] OP_ST   = 8'h10;
  localparam logic [OPC_W-1:0] OP_IN   = 8'h11;
  localparam logic [OPC_W-1:0] OP_OUT  = 8'h12;
  localparam logic [OPC_W-1:0] OP_ADC  = 8'h13;
  localparam logic [OPC_W-1:0] OP_SBB  = 8'h14;
  localparam logic [OPC_W-1:0] OP_NEG  = 8'h15;
  localparam logic [OPC_W-1:0] OP_ASL  = 8'h16;
  localparam logic [OPC_W-1:0] OP_ASR  = 8'h17;
  localparam logic [OPC_W-1:0] OP_JREG = 8'h18;
  localparam logic [OPC_W-1:0] OP_LNXT = 8'h19;
  localparam logic [OPC_W-1:0] OP_LCON = 8'h20;
  localparam logic [OPC_W-1:0] OP_JMP  = 8'h21;
  localparam logic [OPC_W-1:0] OP_JZ   = 8'h22;
  localparam logic [OPC_W-1:0] OP_JNZ  = 8'h23;
  localparam logic [OPC_W-1:0] OP_JL   = 8'h24;
  localparam logic [OPC_W-1:0] OP_JNL  = 8'h25;
  localparam logic [OPC_W-1:0] OP_JG   = 8'h26;
  localparam logic [OPC_W-1:0] OP_JNG  = 8'h27;

  // ALU select bit positions
  localparam int A_MOV = 0,  A_AND = 1,  A_OR  = 2,  A_NOT = 3,  A_XOR = 4;
  localparam int A_ADD = 5,  A_SUB = 6,  A_INC = 7,  A_DEC = 8,  A_SHL = 9;
  localparam int A_SHR = 10, A_ROL = 11, A_ROR = 12, A_CMP = 13, A_ADC = 14;
  localparam int A_SBB = 15, A_NEG = 16, A_ASL = 17, A_ASR = 18, A_IMM = 19;
  localparam int A_NXT = 20;

  // jump select bit positions
  localparam int J_REG = 0, J_ABS = 1, J_Z = 2, J_NZ = 3;
  localparam int J_L   = 4, J_NL  = 5, J_G = 6, J_NG = 7;

  typedef struct packed {
    logic [ALU_N-1:0] alu_sel;
    logic [JMP_N-1:0] jmp_sel;
    logic             reg_we;
    logic             mem_rd;
    logic             mem_wr;
    logic             port_rd;
    logic             port_wr;
    logic             illegal;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/vl_field_split.sv
module vl_field_split
  import vl_dec_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output logic [OPC_W-1:0]  opcode_o,
  output logic              long_o,
  output logic [REG_W-1:0]  ra_o,
  output logic [REG_W-1:0]  rb_o,
  output logic [IMM_W-1:0]  imm_o
);
  logic is_long;

  assign opcode_o = insn_i[OPC_W-1:0];
  assign is_long  = (insn_i[OPC_W-1:0] >= LONG_BASE);
  assign long_o   = is_long;
  assign ra_o     = insn_i[RA_LSB +: REG_W];
  // reserved nibble of long words is dropped; upper half of short words is not ours
  assign rb_o     = is_long ? '0 : insn_i[RB_LSB +: REG_W];
  assign imm_o    = is_long ? insn_i[IMM_LSB +: IMM_W] : '0;
endmodule

// File: rtl/vl_ctrl_table.sv
module vl_ctrl_table
  import vl_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o
);
  ctrl_t c;

  always_comb begin
    c = '0;
    unique case (opcode_i)
      OP_NOP:  ;
      OP_MOV:  begin c.alu_sel[A_MOV] = 1'b1; c.reg_we = 1'b1; end
      OP_AND:  begin c.alu_sel[A_AND] = 1'b1; c.reg_we = 1'b1; end
      OP_OR:   begin c.alu_sel[A_OR]  = 1'b1; c.reg_we = 1'b1; end
      OP_NOT:  begin c.alu_sel[A_NOT] = 1'b1; c.reg_we = 1'b1; end
      OP_XOR:  begin c.alu_sel[A_XOR] = 1'b1; c.reg_we = 1'b1; end
      OP_ADD:  begin c.alu_sel[A_ADD] = 1'b1; c.reg_we = 1'b1; end
      OP_SUB:  begin c.alu_sel[A_SUB] = 1'b1; c.reg_we = 1'b1; end
      OP_INC:  begin c.alu_sel[A_INC] = 1'b1; c.reg_we = 1'b1; end
      OP_DEC:  begin c.alu_sel[A_DEC] = 1'b1; c.reg_we = 1'b1; end
      OP_SHL:  begin c.alu_sel[A_SHL] = 1'b1; c.reg_we = 1'b1; end
      OP_SHR:  begin c.alu_sel[A_SHR] = 1'b1; c.reg_we = 1'b1; end
      OP_ROL:  begin c.alu_sel[A_ROL] = 1'b1; c.reg_we = 1'b1; end
      OP_ROR:  begin c.alu_sel[A_ROR] = 1'b1; c.reg_we = 1'b1; end
      OP_CMP:  c.alu_sel[A_CMP] = 1'b1;  // flags only
      OP_LD:   begin c.mem_rd  = 1'b1; c.reg_we = 1'b1; end
      OP_ST:   c.mem_wr = 1'b1;
      OP_IN:   begin c.port_rd = 1'b1; c.reg_we = 1'b1; end
      OP_OUT:  c.port_wr = 1'b1;
      OP_ADC:  begin c.alu_sel[A_ADC] = 1'b1; c.reg_we = 1'b1; end
      OP_SBB:  begin c.alu_sel[A_SBB] = 1'b1; c.reg_we = 1'b1; end
      OP_NEG:  begin c.alu_sel[A_NEG] = 1'b1; c.reg_we = 1'b1; end
      OP_ASL:  begin c.alu_sel[A_ASL] = 1'b1; c.reg_we = 1'b1; end
      OP_ASR:  begin c.alu_sel[A_ASR] = 1'b1; c.reg_we = 1'b1; end
      OP_JREG: c.jmp_sel[J_REG] = 1'b1;
      OP_LNXT: begin c.alu_sel[A_NXT] = 1'b1; c.reg_we = 1'b1; end
      OP_LCON: begin c.alu_sel[A_IMM] = 1'b1; c.reg_we = 1'b1; end
      OP_JMP:  c.jmp_sel[J_ABS] = 1'b1;
      OP_JZ:   c.jmp_sel[J_Z]   = 1'b1;
      OP_JNZ:  c.jmp_sel[J_NZ]  = 1'b1;
      OP_JL:   c.jmp_sel[J_L]   = 1'b1;
      OP_JNL:  c.jmp_sel[J_NL]  = 1'b1;
      OP_JG:   c.jmp_sel[J_G]   = 1'b1;
      OP_JNG:  c.jmp_sel[J_NG]  = 1'b1;
      default: c.illegal = 1'b1;  // decodes as no-op
    endcase
  end

  assign ctrl_o = c;
endmodule

// File: rtl/vl_out_stage.sv
module vl_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d_i;
      end
      assign q_o = q;
    end else begin : g_bypass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/vl_insn_decoder.sv
module vl_insn_decoder
  import vl_dec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INSN_W-1:0] insn_i,
  output logic [OPC_W-1:0]  opcode_o,
  output logic              long_o,
  output logic [REG_W-1:0]  ra_o,
  output logic [REG_W-1:0]  rb_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [ALU_N-1:0]  alu_sel_o,
  output logic [JMP_N-1:0]  jmp_sel_o,
  output logic              reg_we_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              port_rd_o,
  output logic              port_wr_o,
  output logic              illegal_o
);
  localparam int DW = OPC_W + 1 + 2*REG_W + IMM_W + CTRL_W;

  logic [OPC_W-1:0] opc_d;
  logic             long_d;
  logic [REG_W-1:0] ra_d, rb_d;
  logic [IMM_W-1:0] imm_d;
  ctrl_t            ctrl_d, ctrl_q;
  logic [DW-1:0]    pk_d, pk_q;

  vl_field_split i_split (
    .insn_i   (insn_i),
    .opcode_o (opc_d),
    .long_o   (long_d),
    .ra_o     (ra_d),
    .rb_o     (rb_d),
    .imm_o    (imm_d)
  );

  vl_ctrl_table i_table (
    .opcode_i (opc_d),
    .ctrl_o   (ctrl_d)
  );

  assign pk_d = {opc_d, long_d, ra_d, rb_d, imm_d, ctrl_d};

  vl_out_stage #(.W(DW), .REG_OUT(REG_OUT)) i_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pk_d),
    .q_o    (pk_q)
  );

  assign {opcode_o, long_o, ra_o, rb_o, imm_o, ctrl_q} = pk_q;
  assign alu_sel_o = ctrl_q.alu_sel;
  assign jmp_sel_o = ctrl_q.jmp_sel;
  assign reg_we_o  = ctrl_q.reg_we;
  assign mem_rd_o  = ctrl_q.mem_rd;
  assign mem_wr_o  = ctrl_q.mem_wr;
  assign port_rd_o = ctrl_q.port_rd;
  assign port_wr_o = ctrl_q.port_wr;
  assign illegal_o = ctrl_q.illegal;

  assert_short_imm_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !long_o |-> imm_o == '0);
  assert_long_rb_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_o |-> rb_o == '0);
  assert_cmp_no_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_o == OP_CMP |-> !reg_we_o);
  assert_long_jump_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_sel_o != '0 && !jmp_sel_o[J_REG]) |-> long_o);
  assert_illegal_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (alu_sel_o == '0 && jmp_sel_o == '0 && !reg_we_o &&
                   !mem_rd_o && !mem_wr_o && !port_rd_o && !port_wr_o));
  assert_short_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !long_o) |-> opcode_o >= 8'h1A);
  assert_alu_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alu_sel_o));
  assert_jmp_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(jmp_sel_o));
  assert_xfer_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mem_rd_o, mem_wr_o, port_rd_o, port_wr_o}) <= 1);
endmodule

// File: tb/test_vl_insn_decoder.sv
`timescale 1ns/1ps
module test_vl_insn_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn = '0;

  logic [7:0]  opcode_o;
  logic        long_o;
  logic [3:0]  ra_o, rb_o;
  logic [15:0] imm_o;
  logic [20:0] alu_sel_o;
  logic [7:0]  jmp_sel_o;
  logic        reg_we_o, mem_rd_o, mem_wr_o, port_rd_o, port_wr_o, illegal_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  vl_insn_decoder i_vl_insn_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .insn_i(insn),
    .opcode_o(opcode_o), .long_o(long_o), .ra_o(ra_o), .rb_o(rb_o),
    .imm_o(imm_o), .alu_sel_o(alu_sel_o), .jmp_sel_o(jmp_sel_o),
    .reg_we_o(reg_we_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .port_rd_o(port_rd_o), .port_wr_o(port_wr_o), .illegal_o(illegal_o)
  );

  typedef struct packed {
    logic [7:0]  opc;
    logic        lng;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [15:0] imm;
    logic [20:0] alu;
    logic [7:0]  jmp;
    logic        we, mrd, mwr, prd, pwr, ill;
  } exp_t;

  exp_t exp_q[$];

  function automatic exp_t model(logic [31:0] w);
    exp_t e;
    logic [7:0] o;
    int idx;
    e = '0;
    o = w[7:0];
    e.opc = o;
    e.lng = (o >= 8'h20);
    e.ra  = w[11:8];
    if (e.lng) e.imm = w[31:16];
    else       e.rb  = w[15:12];
    idx = -1;
    if (o >= 8'h01 && o <= 8'h0E)      idx = int'(o) - 1;
    else if (o >= 8'h13 && o <= 8'h17) idx = int'(o) - 8'h13 + 14;
    else if (o == 8'h19)               idx = 20;
    else if (o == 8'h20)               idx = 19;
    if (idx >= 0) e.alu[idx] = 1'b1;
    if (o == 8'h18) e.jmp[0] = 1'b1;
    if (o >= 8'h21 && o <= 8'h27) e.jmp[int'(o) - 8'h20] = 1'b1;
    e.mrd = (o == 8'h0F);
    e.mwr = (o == 8'h10);
    e.prd = (o == 8'h11);
    e.pwr = (o == 8'h12);
    e.we  = (e.alu != '0 && o != 8'h0E) || o == 8'h0F || o == 8'h11;
    e.ill = (o >= 8'h1A && o <= 8'h1F) || o > 8'h27;
    return e;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] w);
    @(negedge clk);
    insn = w;
    exp_q.push_back(model(w));
  endtask

  // monitor: one cycle after the word is applied
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni && exp_q.size() > 0) begin
        exp_t e;
        string ctag;
        e = exp_q.pop_front();
        ctag = (e.opc == 8'h00) ? "R10" : "R5";
        chk(opcode_o == e.opc && long_o == e.lng, "R1", {opcode_o, long_o}, {e.opc, e.lng});
        chk(ra_o == e.ra, "R2", ra_o, e.ra);
        chk(rb_o == e.rb, e.lng ? "R4 rb" : "R3 rb", rb_o, e.rb);
        chk(imm_o == e.imm, e.lng ? "R4 imm" : "R3 imm", imm_o, e.imm);
        chk(alu_sel_o == e.alu, ctag, alu_sel_o, e.alu);
        chk(reg_we_o == e.we, (e.opc == 8'h00) ? "R10 we" : "R6", reg_we_o, e.we);
        chk({mem_rd_o, mem_wr_o, port_rd_o, port_wr_o} == {e.mrd, e.mwr, e.prd, e.pwr}, "R7",
            {mem_rd_o, mem_wr_o, port_rd_o, port_wr_o}, {e.mrd, e.mwr, e.prd, e.pwr});
        chk(jmp_sel_o == e.jmp, "R8", jmp_sel_o, e.jmp);
        chk(illegal_o == e.ill, e.ill ? "R9" : "R10 ill", illegal_o, e.ill);
        chk($countones(alu_sel_o) <= 1 && $countones(jmp_sel_o) <= 1, "R12",
            {alu_sel_o, jmp_sel_o}, 0);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=1 exp=0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    insn = 32'hFFFF_FF26;
    repeat (3) @(negedge clk);
    // R11: outputs zero under reset
    chk({opcode_o, long_o, imm_o, alu_sel_o, jmp_sel_o, reg_we_o, illegal_o} == '0,
        "R11 reset", {opcode_o, imm_o, jmp_sel_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11: no change before the edge
    insn = 32'h1234_3A06;
    #1;
    chk(opcode_o == 8'h26, "R11 latency", opcode_o, 8'h26);
    exp_q.push_back(model(insn));

    // R1..R10: every opcode, varied fields
    for (int o = 0; o < 256; o++) begin
      logic [15:0] hi;
      hi = 16'(o * 16'h9E37 + 16'h1234);
      drive({hi, 4'(o + 7), 4'(o * 3), 8'(o)});
    end
    // R3: short words with all-ones upper half; R4: long words with reserved set
    drive(32'hFFFF_F50F);
    drive(32'h0000_F50F);
    drive(32'hFFFF_FF11);
    drive(32'hFFFF_0E0E);
    drive(32'hFFFF_F920);
    drive(32'h0000_F020);
    drive(32'h8001_A527);
    drive(32'hFFFF_FF1A);
    drive(32'hFFFF_FF28);
    drive(32'hFFFF_FFFF);
    drive(32'h0000_0000);  // R10
    repeat (3) @(negedge clk);

    // R11: asynchronous reset mid-stream
    insn = 32'h5555_F721;
    @(negedge clk);
    #1;
    chk(jmp_sel_o == 8'h02, "R11 pre-reset", jmp_sel_o, 8'h02);
    rst_ni = 1'b0;
    #0.5;
    chk({opcode_o, long_o, ra_o, imm_o, jmp_sel_o, reg_we_o} == '0, "R11 async clear",
        {opcode_o, imm_o, jmp_sel_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    drive(32'h0000_2113);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule